// File: doc/BRIEF.md
# Accumulator Datapath with Extend Flip-Flop

This block holds the working accumulator of a small single-accumulator processor, together with the one-bit extend flip-flop that takes carries and acts as the extra bit in rotates. Each cycle, at most one decoded operation strobe arrives from an outside sequencer. The block forms the next accumulator and extend values from the current accumulator, a data-register operand and an eight-bit input character. It drives the accumulator register's load, increment and clear controls itself.

Word-wide logic, addition, loads and rotates pass through a combinational adder-and-logic stage, and the result is loaded into the register. Increment and clear use the register's own counter controls and do not go through that stage. The accumulator value is always visible at the output, along with a zero flag and a sign flag that a skip decoder can test.

Top module: `acc_unit`

## Requirements
- R1: While `rst_n` is low, and after it returns high with no strobe, the accumulator is 0x0000 and the extend bit is 0.
- R2: `op_and` makes the accumulator equal to the bitwise AND of its old value and `dr_in`. The extend bit is unchanged.
- R3: `op_add` makes the accumulator equal to (old value + `dr_in`) modulo 2^16, and the carry out of bit 15 is loaded into the extend bit.
- R4: `op_ldr` copies `dr_in` into the accumulator. The extend bit is unchanged.
- R5: `op_inp` loads `inpr_in` into accumulator bits 7:0. Bits 15:8 and the extend bit keep their values.
- R6: `op_cma` replaces the accumulator with its bitwise inverse. The extend bit is unchanged.
- R7: `op_shr` rotates right through the extend bit. New bit 15 is the old extend bit, new bits 14:0 are old bits 15:1, and the new extend bit is old bit 0.
- R8: `op_shl` rotates left through the extend bit. New bit 0 is the old extend bit, new bits 15:1 are old bits 14:0, and the new extend bit is old bit 15.
- R9: `op_inc` adds one to the accumulator modulo 2^16, so 0xFFFF becomes 0x0000. The extend bit is unchanged.
- R10: `op_clr` sets the accumulator to 0x0000. The extend bit is unchanged.
- R11: `op_cle` sets the extend bit to 0 and `op_cme` inverts it. Neither changes the accumulator.
- R12: In a cycle with no strobe, the accumulator and the extend bit hold their values.
- R13: `ac_zero` is 1 exactly when the accumulator is 0x0000, and `ac_neg` equals accumulator bit 15. Both follow the register output with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr_in | input | 16 | Data-register operand |
| inpr_in | input | 8 | Input character |
| op_and | input | 1 | AND operand into accumulator |
| op_add | input | 1 | Add operand, carry to extend bit |
| op_ldr | input | 1 | Load operand into accumulator |
| op_inp | input | 1 | Load input character into low byte |
| op_cma | input | 1 | Complement accumulator |
| op_shr | input | 1 | Rotate right through extend bit |
| op_shl | input | 1 | Rotate left through extend bit |
| op_inc | input | 1 | Increment accumulator |
| op_clr | input | 1 | Clear accumulator |
| op_cle | input | 1 | Clear extend bit |
| op_cme | input | 1 | Complement extend bit |
| ac_out | output | 16 | Accumulator value |
| e_out | output | 1 | Extend bit |
| ac_zero | output | 1 | Accumulator is zero |
| ac_neg | output | 1 | Accumulator sign bit |

## Verification
The assertions assume that the sequencer raises at most one strobe per cycle. If two were raised together, the hold and per-operation properties would not describe any defined behaviour. The stimulus keeps to this assumption: each random step picks a single operation code, or none, and converts it into exactly one raised strobe. Operands and characters are drawn freely. Directed steps add the carry wrap, increment wrap, rotate and byte-preservation corners.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam int unsigned ACC_W_DEF  = 16;
   localparam int unsigned CHAR_W_DEF = 8;

   typedef enum logic [1:0] {
      E_HOLD  = 2'd0,
      E_LOAD  = 2'd1,
      E_CLEAR = 2'd2,
      E_FLIP  = 2'd3
   } e_ctl_t;
endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
   parameter int unsigned W     = 16,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   if (W < 2) begin : g_bad_w
      $error("acc_adder: W must be at least 2");
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0] c;
      assign c[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
         assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
      end
      assign cout_o = c[W];
   end else begin : g_behav
      logic [W:0] full;
      assign full   = {1'b0, a_i} + {1'b0, b_i};
      assign sum_o  = full[W-1:0];
      assign cout_o = full[W];
   end
endmodule

// File: rtl/acc_logic.sv
module acc_logic
   import acc_pkg::*;
#(
   parameter int unsigned W      = ACC_W_DEF,
   parameter int unsigned CW     = CHAR_W_DEF,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic [W-1:0]  ac_i,
   input  logic          e_i,
   input  logic [W-1:0]  dr_i,
   input  logic [CW-1:0] chr_i,
   input  logic          s_and,
   input  logic          s_add,
   input  logic          s_ldr,
   input  logic          s_inp,
   input  logic          s_cma,
   input  logic          s_shr,
   input  logic          s_shl,
   input  logic          s_cle,
   input  logic          s_cme,
   output logic          ld_o,
   output logic [W-1:0]  val_o,
   output e_ctl_t        ectl_o,
   output logic          e_val_o
);
   logic [W-1:0] sum;
   logic         cout;
   logic [W-1:0] inp_val;

   acc_adder #(.W(W), .RIPPLE(RIPPLE)) u_add (
      .a_i(ac_i), .b_i(dr_i), .sum_o(sum), .cout_o(cout)
   );

   if (CW > W) begin : g_bad_cw
      $error("acc_logic: character wider than accumulator");
   end else if (CW == W) begin : g_inp_full
      assign inp_val = chr_i;
   end else begin : g_inp_low
      assign inp_val = {ac_i[W-1:CW], chr_i};
   end

   always_comb begin
      ld_o    = 1'b0;
      val_o   = ac_i;
      ectl_o  = E_HOLD;
      e_val_o = e_i;
      if (s_and) begin
         ld_o  = 1'b1;
         val_o = ac_i & dr_i;
      end else if (s_add) begin
         ld_o    = 1'b1;
         val_o   = sum;
         ectl_o  = E_LOAD;
         e_val_o = cout;
      end else if (s_ldr) begin
         ld_o  = 1'b1;
         val_o = dr_i;
      end else if (s_inp) begin
         ld_o  = 1'b1;
         val_o = inp_val;
      end else if (s_cma) begin
         ld_o  = 1'b1;
         val_o = ~ac_i;
      end else if (s_shr) begin
         ld_o    = 1'b1;
         val_o   = {e_i, ac_i[W-1:1]};
         ectl_o  = E_LOAD;
         e_val_o = ac_i[0];
      end else if (s_shl) begin
         ld_o    = 1'b1;
         val_o   = {ac_i[W-2:0], e_i};
         ectl_o  = E_LOAD;
         e_val_o = ac_i[W-1];
      end else if (s_cle) begin
         ectl_o = E_CLEAR;
      end else if (s_cme) begin
         ectl_o = E_FLIP;
      end
   end
endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic         inr,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (inr) q <= q + 1'b1;
      else if (ld)  q <= d;
   end

   p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));
   p_inr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inr && !clr) |=> (q == $past(q) + 1'b1));
endmodule

// File: rtl/acc_unit.sv
module acc_unit
   import acc_pkg::*;
#(
   parameter int unsigned ACC_W  = ACC_W_DEF,
   parameter int unsigned CHAR_W = CHAR_W_DEF,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ACC_W-1:0]  dr_in,
   input  logic [CHAR_W-1:0] inpr_in,
   input  logic              op_and,
   input  logic              op_add,
   input  logic              op_ldr,
   input  logic              op_inp,
   input  logic              op_cma,
   input  logic              op_shr,
   input  logic              op_shl,
   input  logic              op_inc,
   input  logic              op_clr,
   input  logic              op_cle,
   input  logic              op_cme,
   output logic [ACC_W-1:0]  ac_out,
   output logic              e_out,
   output logic              ac_zero,
   output logic              ac_neg
);
   localparam int unsigned MSB = ACC_W - 1;

   logic [ACC_W-1:0] ac_q;
   logic [ACC_W-1:0] ld_val;
   logic             ac_ld;
   logic             e_q;
   logic             e_val;
   e_ctl_t           e_ctl;

   acc_logic #(.W(ACC_W), .CW(CHAR_W), .RIPPLE(RIPPLE)) u_logic (
      .ac_i(ac_q), .e_i(e_q), .dr_i(dr_in), .chr_i(inpr_in),
      .s_and(op_and), .s_add(op_add), .s_ldr(op_ldr), .s_inp(op_inp),
      .s_cma(op_cma), .s_shr(op_shr), .s_shl(op_shl),
      .s_cle(op_cle), .s_cme(op_cme),
      .ld_o(ac_ld), .val_o(ld_val), .ectl_o(e_ctl), .e_val_o(e_val)
   );

   acc_reg #(.W(ACC_W)) u_ac (
      .clk(clk), .rst_n(rst_n), .ld(ac_ld), .inr(op_inc), .clr(op_clr),
      .d(ld_val), .q(ac_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) e_q <= 1'b0;
      else begin
         unique case (e_ctl)
            E_LOAD:  e_q <= e_val;
            E_CLEAR: e_q <= 1'b0;
            E_FLIP:  e_q <= ~e_q;
            default: e_q <= e_q;
         endcase
      end
   end

   assign ac_out  = ac_q;
   assign e_out   = e_q;
   assign ac_zero = ~|ac_q;
   assign ac_neg  = ac_q[MSB];

   logic [10:0] strobes;
   assign strobes = {op_and, op_add, op_ldr, op_inp, op_cma, op_shr,
                     op_shl, op_inc, op_clr, op_cle, op_cme};

   p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobes));
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes == '0) |=> ($stable(ac_q) && $stable(e_q)));
   p_shr_rot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op_shr |=> (ac_q[MSB] == $past(e_q) && e_q == $past(ac_q[0])));
   p_shl_rot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op_shl |=> (ac_q[0] == $past(e_q) && e_q == $past(ac_q[MSB])));
   p_cme_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
      op_cme |=> (e_q != $past(e_q) && $stable(ac_q)));
   p_inc_keep_e_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_inc || op_clr) |=> $stable(e_q));
   p_status_r13: assert property (@(posedge clk) disable iff (!rst_n)
      ac_zero |-> !ac_neg);
endmodule

// File: tb/sim_acc_unit.sv
`timescale 1ns/1ps
module sim_acc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] dr_in = '0;
   logic [7:0]  inpr_in = '0;
   logic op_and = 0, op_add = 0, op_ldr = 0, op_inp = 0, op_cma = 0, op_shr = 0;
   logic op_shl = 0, op_inc = 0, op_clr = 0, op_cle = 0, op_cme = 0;
   logic [15:0] ac_out;
   logic e_out, ac_zero, ac_neg;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;
   logic [15:0] m_ac;
   logic        m_e;

   always #2.5 clk = ~clk;

   acc_unit u0 (
      .clk(clk), .rst_n(rst_n), .dr_in(dr_in), .inpr_in(inpr_in),
      .op_and(op_and), .op_add(op_add), .op_ldr(op_ldr), .op_inp(op_inp),
      .op_cma(op_cma), .op_shr(op_shr), .op_shl(op_shl), .op_inc(op_inc),
      .op_clr(op_clr), .op_cle(op_cle), .op_cme(op_cme),
      .ac_out(ac_out), .e_out(e_out), .ac_zero(ac_zero), .ac_neg(ac_neg)
   );

   // op codes: 0 and,1 add,2 ldr,3 inp,4 cma,5 shr,6 shl,7 inc,8 clr,9 cle,10 cme,11 none
   function automatic string tag_of(int op);
      case (op)
         0: return "R2";  1: return "R3";  2: return "R4";  3: return "R5";
         4: return "R6";  5: return "R7";  6: return "R8";  7: return "R9";
         8: return "R10"; 9: return "R11"; 10: return "R11";
         default: return "R12";
      endcase
   endfunction

   function automatic logic [16:0] model(int op, logic [15:0] a, logic e,
                                         logic [15:0] d, logic [7:0] c);
      logic [16:0] s;
      case (op)
         0: return {e, a & d};
         1: begin s = {1'b0, a} + {1'b0, d}; return {s[16], s[15:0]}; end
         2: return {e, d};
         3: return {e, a[15:8], c};
         4: return {e, ~a};
         5: return {a[0], e, a[15:1]};
         6: return {a[15], a[14:0], e};
         7: return {e, a + 16'd1};
         8: return {e, 16'd0};
         9: return {1'b0, a};
         10: return {~e, a};
         default: return {e, a};
      endcase
   endfunction

   task automatic check(string tag, logic [15:0] exp_ac, logic exp_e);
      n_cmp++;
      if (ac_out !== exp_ac || e_out !== exp_e) begin
         n_bad++;
         $display("FAIL %s: ac=%h e=%b expected ac=%h e=%b", tag, ac_out, e_out, exp_ac, exp_e);
      end
      n_cmp++;
      if (ac_zero !== (exp_ac == 16'd0) || ac_neg !== exp_ac[15]) begin
         n_bad++;
         $display("FAIL R13: zero=%b neg=%b expected zero=%b neg=%b",
                  ac_zero, ac_neg, exp_ac == 16'd0, exp_ac[15]);
      end
   endtask

   task automatic step(int op, logic [15:0] d, logic [7:0] c);
      logic [16:0] nx;
      @(negedge clk);
      dr_in = d; inpr_in = c;
      op_and = (op == 0); op_add = (op == 1); op_ldr = (op == 2);
      op_inp = (op == 3); op_cma = (op == 4); op_shr = (op == 5);
      op_shl = (op == 6); op_inc = (op == 7); op_clr = (op == 8);
      op_cle = (op == 9); op_cme = (op == 10);
      nx = model(op, m_ac, m_e, d, c);
      @(posedge clk);
      #1;
      m_ac = nx[15:0]; m_e = nx[16];
      check(tag_of(op), m_ac, m_e);
      @(negedge clk);
      {op_and, op_add, op_ldr, op_inp, op_cma, op_shr} = '0;
      {op_shl, op_inc, op_clr, op_cle, op_cme} = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      m_ac = '0; m_e = 1'b0;
      repeat (3) @(posedge clk);
      #1 check("R1", 16'd0, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1 check("R1", 16'd0, 1'b0);

      // R3 carry wrap to zero, E set
      step(2, 16'hFFFF, 8'h00);
      step(1, 16'h0001, 8'h00);
      // R9 increment wrap keeps E
      step(2, 16'hFFFF, 8'h00);
      step(7, 16'h0000, 8'h00);
      // R7 / R8 rotate through E
      step(2, 16'h8001, 8'h00);
      step(5, 16'h0000, 8'h00);
      step(6, 16'h0000, 8'h00);
      step(6, 16'h0000, 8'h00);
      // R5 upper byte kept
      step(2, 16'hA55A, 8'h00);
      step(3, 16'h0000, 8'h3C);
      // R11 E ops leave AC
      step(10, 16'h0000, 8'h00);
      step(9, 16'h0000, 8'h00);
      step(10, 16'h0000, 8'h00);
      // R6, R2, R10, R12
      step(4, 16'h0000, 8'h00);
      step(0, 16'hF0F0, 8'h00);
      step(8, 16'h1234, 8'h00);
      step(11, 16'hFFFF, 8'hFF);

      for (int i = 0; i < 400; i++) begin
         step(int'($urandom_range(11, 0)), 16'($urandom), 8'($urandom));
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule